// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames as a byte stream, delimited by start and end markers, and stores them in memory through a ring of descriptors. Each descriptor is four 32-bit words at consecutive word addresses: status, control, buffer address and next-descriptor address. The engine reads a descriptor, checks that hardware owns it, and fills its buffer with up to the configured number of bytes. It then writes a status word that hands the descriptor back to software and records the length, the position of the descriptor in the frame, and the frame flags. A frame longer than one buffer continues in the following descriptors.

Software programs the block through three small registers: a run control, the address of the first descriptor, and a count of frames lost because no hardware-owned descriptor was ready. The memory port is a single word-wide port. A read returns its data on the cycle after the request, and writes carry per-byte enables. The byte stream is throttled by `rx_ready` while the engine is busy with descriptor traffic.

Top module: `rxr_ring_writer`

## Requirements
- R1: When started, the engine reads the four descriptor words at the current address, which is byte address +0, +4, +8 and +12. If control bit 24 is set, the next descriptor is taken from the fourth word. Otherwise it is the current address plus 16.
- R2: Frame data is written only into a descriptor whose status bit 31 read as 1. The status written back has bit 31 cleared.
- R3: Byte k of a buffer lands at buffer address + k, little-endian within each 32-bit word. Byte enables leave every byte past the last received one untouched.
- R4: A buffer holds at most control bits 10:0 bytes. Status bit 9 is set only in the first descriptor of a frame and bit 8 only in the last. A frame that fits in one buffer has both set.
- R5: Status bits 29:16 hold the number of frame bytes received up to the end of that descriptor, with the CRC bytes counted. In the last descriptor this is the whole frame length.
- R6: Status bit 10 (multicast) equals bit 0 of the frame's first byte, in every descriptor of that frame.
- R7: In the last descriptor only, bit 1 records `rx_crc_err` as sampled with the end byte. Bit 11 marks a frame shorter than RUNT_MIN bytes, and bit 15 is the OR of bits 1 and 11.
- R8: A frame whose start finds the current descriptor owned by software is discarded whole and adds one to the missed count, and nothing is written. The descriptor is polled again until hardware owns it.
- R9: If the next descriptor of a spanning frame is owned by software, the rest of that frame is discarded and the missed count advances by one.
- R10: Registers: address 0 bit 1 = run, address 1 = descriptor base (loaded as current address while stopped), address 2 = missed count (read only). With run clear, no memory access occurs and incoming bytes are discarded.
- R11: `rx_ready` is low while a descriptor is fetched or a status word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_crc_err | input | 1 | CRC error flag, valid with the end byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, one cycle after the request |

## Verification
On every cycle, the assertions check the following: data writes happen only while an owned descriptor is held, and never land past the buffer's configured size. A status write reports a length no smaller than the bytes in its own buffer, the missed count moves only on a drop event, and a stopped engine makes no memory access. Only the bench's scenarios can show that the bytes and status words in memory are correct. That covers first/last/multicast/CRC/runt flags across a sweep of frame lengths and buffer sizes, unchained ring stepping, and whole-frame and mid-frame drops with their count. It also covers discarding while stopped.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int ST_OWN   = 31;
  localparam int ST_LEN   = 16;
  localparam int ST_ESUM  = 15;
  localparam int ST_RUNT  = 11;
  localparam int ST_MCAST = 10;
  localparam int ST_FIRST = 9;
  localparam int ST_LAST  = 8;
  localparam int ST_CRC   = 1;
  localparam int CT_CHAIN = 24;
  localparam int RUN_BIT  = 1;
  localparam int LEN_W    = 14;
  localparam int BSZ_W    = 11;

  typedef enum logic [2:0] {
    S_STOP, S_FETCH, S_WAIT, S_READY, S_NOTOWN, S_DATA, S_STATUS, S_DROP
  } rx_state_e;

  function automatic logic [31:0] compose_status(
    input logic [LEN_W-1:0] len, input logic first, input logic last,
    input logic mcast, input logic crc, input logic runt);
    logic [31:0] st;
    st = '0;
    st[ST_LEN +: LEN_W] = len;
    st[ST_FIRST] = first;
    st[ST_LAST]  = last;
    st[ST_MCAST] = mcast;
    st[ST_CRC]   = crc;
    st[ST_RUNT]  = runt;
    st[ST_ESUM]  = crc | runt;
    return st;
  endfunction

  function automatic logic [31:0] next_desc(
    input logic [31:0] cur, input logic chained, input logic [31:0] link);
    return chained ? link : cur + 32'd16;
  endfunction

endpackage

// File: rtl/rxr_regs.sv
module rxr_regs #(
  parameter int MISS_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        miss_inc,
  output logic        run,
  output logic [31:0] ring_base,
  output logic        base_load
);
  import rxr_pkg::*;

  logic [MISS_W-1:0] miss_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      ring_base <= '0;
      base_load <= 1'b0;
      miss_cnt  <= '0;
    end else begin
      base_load <= 1'b0;
      if (cfg_we && cfg_addr == 2'd0) run <= cfg_wdata[RUN_BIT];
      if (cfg_we && cfg_addr == 2'd1) begin
        ring_base <= cfg_wdata;
        base_load <= 1'b1;
      end
      if (miss_inc) miss_cnt <= miss_cnt + 1'b1;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      2'd0: cfg_rdata[RUN_BIT] = run;
      2'd1: cfg_rdata = ring_base;
      2'd2: cfg_rdata[MISS_W-1:0] = miss_cnt;
      default: cfg_rdata = '0;
    endcase
  end

  // R8 / R9: the lost-frame count only moves on a drop event
  a_r8_miss_only_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miss_cnt) |-> $past(miss_inc));

endmodule

// File: rtl/rxr_lane_pack.sv
module rxr_lane_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        flush,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  input  logic [31:0] waddr_in,
  output logic        wr_pend,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic [3:0]  wr_be
);
  logic [31:0] wbuf, wbuf_n;
  logic [3:0]  be_acc, be_n;

  always_comb begin
    wbuf_n = wbuf;
    wbuf_n[{lane, 3'b000} +: 8] = din;
    be_n = be_acc | (4'b0001 << lane);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf <= '0; be_acc <= '0;
      wr_pend <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_be <= '0;
    end else begin
      wr_pend <= 1'b0;
      if (take) begin
        if (flush) begin
          wr_pend <= 1'b1;
          wr_addr <= waddr_in;
          wr_data <= wbuf_n;
          wr_be   <= be_n;
          wbuf    <= '0;
          be_acc  <= '0;
        end else begin
          wbuf   <= wbuf_n;
          be_acc <= be_n;
        end
      end
    end
  end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
  parameter int MISS_W   = 16,
  parameter int RUNT_MIN = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_crc_err,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic [31:0] mem_rdata
);
  import rxr_pkg::*;

  rx_state_e        state;
  logic [1:0]       fk;
  logic [31:0]      cur, d_buf, d_nxt;
  logic             d_own, d_chain, cont;
  logic [BSZ_W-1:0] d_bsz, bcnt;
  logic [LEN_W-1:0] flen;
  logic             mc_q, first_q, last_q, crc_q;

  logic        run, base_load, miss_inc;
  logic [31:0] ring_base;
  logic        take, buf_full, buf_done, flush, st_we, runt;
  logic [31:0] waddr, st_word;
  logic        wr_pend;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;

  rxr_regs #(.MISS_W(MISS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .miss_inc(miss_inc),
    .run(run), .ring_base(ring_base), .base_load(base_load));

  assign rx_ready = state inside {S_STOP, S_READY, S_NOTOWN, S_DATA, S_DROP};
  assign take     = rx_valid && rx_ready &&
                    ((state == S_READY && rx_sof && run && !base_load) || state == S_DATA);
  assign buf_full = ({1'b0, bcnt} + 12'd1) == {1'b0, d_bsz};
  assign buf_done = take && (rx_eof || buf_full);
  assign flush    = take && (bcnt[1:0] == 2'd3 || rx_eof || buf_full);
  assign waddr    = d_buf + {21'b0, bcnt[BSZ_W-1:2], 2'b00};
  assign st_we    = (state == S_STATUS) && !wr_pend;
  assign runt     = last_q && (flen < LEN_W'(RUNT_MIN));
  assign st_word  = compose_status(flen, first_q, last_q, mc_q, crc_q, runt);
  assign miss_inc = (state == S_NOTOWN && run && !base_load && rx_valid && rx_sof) ||
                    (state == S_WAIT && fk == 2'd3 && cont && !d_own);

  rxr_lane_pack u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .flush(flush), .lane(bcnt[1:0]),
    .din(rx_data), .waddr_in(waddr), .wr_pend(wr_pend), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be));

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0; mem_be = '0;
    if (wr_pend) begin
      mem_req = 1'b1; mem_we = 1'b1; mem_addr = wr_addr;
      mem_wdata = wr_data; mem_be = wr_be;
    end else if (state == S_FETCH) begin
      mem_req = 1'b1; mem_addr = cur + {28'b0, fk, 2'b00};
    end else if (st_we) begin
      mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur;
      mem_wdata = st_word; mem_be = 4'hF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_STOP; fk <= '0; cur <= '0; d_own <= 1'b0; d_bsz <= '0;
      d_chain <= 1'b0; d_buf <= '0; d_nxt <= '0; cont <= 1'b0; bcnt <= '0;
      flen <= '0; mc_q <= 1'b0; first_q <= 1'b0; last_q <= 1'b0; crc_q <= 1'b0;
    end else begin
      if (take) begin
        bcnt <= bcnt + 1'b1;
        if (state == S_READY) begin
          flen <= LEN_W'(1); mc_q <= rx_data[0]; first_q <= 1'b1;
        end else begin
          flen <= flen + 1'b1;
        end
        if (buf_done) begin
          last_q <= rx_eof;
          crc_q  <= rx_eof & rx_crc_err;
        end
      end
      case (state)
        S_STOP: begin
          if (base_load) cur <= ring_base;
          if (run) begin state <= S_FETCH; fk <= '0; cont <= 1'b0; end
        end
        S_FETCH: state <= S_WAIT;
        S_WAIT: begin
          case (fk)
            2'd0: d_own <= mem_rdata[ST_OWN];
            2'd1: begin d_bsz <= mem_rdata[BSZ_W-1:0]; d_chain <= mem_rdata[CT_CHAIN]; end
            2'd2: d_buf <= mem_rdata;
            default: d_nxt <= mem_rdata;
          endcase
          if (fk != 2'd3) begin
            fk <= fk + 1'b1; state <= S_FETCH;
          end else if (cont) begin
            if (d_own) state <= S_DATA;
            else begin state <= S_DROP; cont <= 1'b0; end
          end else begin
            state <= d_own ? S_READY : S_NOTOWN;
          end
        end
        S_READY: begin
          if (base_load) begin cur <= ring_base; state <= S_STOP; end
          else if (!run) state <= S_STOP;
          else if (take) state <= buf_done ? S_STATUS : S_DATA;
        end
        S_DATA: if (buf_done) state <= S_STATUS;
        S_STATUS: if (!wr_pend) begin
          cur <= next_desc(cur, d_chain, d_nxt);
          cont <= !last_q; bcnt <= '0; first_q <= 1'b0; fk <= '0;
          state <= S_FETCH;
        end
        S_NOTOWN: begin
          if (base_load) begin cur <= ring_base; state <= S_STOP; end
          else if (!run) state <= S_STOP;
          else begin
            fk <= '0;
            state <= (rx_valid && rx_sof && !rx_eof) ? S_DROP : S_FETCH;
          end
        end
        S_DROP: if (rx_valid && rx_eof) begin fk <= '0; state <= S_FETCH; end
        default: state <= S_STOP;
      endcase
    end
  end

  // R2: buffer writes only while a hardware-owned descriptor is held
  a_r2_owned_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |-> d_own);
  // R4: no data word lands beyond the configured buffer size
  a_r4_within_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && d_bsz != '0) |-> ((wr_addr - d_buf) < {21'b0, d_bsz}));
  // R5: reported length covers at least this buffer's bytes
  a_r5_len_covers_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (mem_wdata[ST_LEN +: LEN_W] >= {3'b0, bcnt}) && (bcnt != '0));
  // R10: a stopped engine makes no memory access
  a_r10_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP) |-> !mem_req);

endmodule

// File: tb/test_rxr_ring_writer.sv
module test_rxr_ring_writer;
  localparam int RUNT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0] mem_be;
  logic [31:0] mem_rdata = '0;

  logic [7:0] mem [0:1023];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int perm [4] = '{0, 2, 1, 3};

  always #2 clk = ~clk;

  rxr_ring_writer #(.MISS_W(16), .RUNT_MIN(RUNT)) i_rxr_ring_writer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_crc_err(rx_crc_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[{mem_addr[9:2], 2'(b)}] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= {mem[{mem_addr[9:2], 2'd3}], mem[{mem_addr[9:2], 2'd2}],
                      mem[{mem_addr[9:2], 2'd1}], mem[{mem_addr[9:2], 2'd0}]};
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic wr32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a+b] = v[8*b +: 8];
  endtask

  task automatic set_desc(input int a, input logic [31:0] st, input logic [31:0] ct,
                          input logic [31:0] bp, input logic [31:0] nx);
    wr32(a, st); wr32(a+4, ct); wr32(a+8, bp); wr32(a+12, nx);
  endtask

  function automatic logic [7:0] fbyte(input int seed, input int i, input bit mc);
    logic [7:0] v;
    v = 8'(seed * 16 + i * 3 + 1);
    if (i == 0) v[0] = mc;
    return v;
  endfunction

  function automatic logic [31:0] exp_st(input int L, input int B, input int j,
                                         input bit mc, input bit crc);
    logic [31:0] s;
    int n;
    bit last, rn;
    n = (L + B - 1) / B;
    last = (j == n - 1);
    s = '0;
    s[29:16] = 14'(last ? L : (j + 1) * B);
    s[9] = (j == 0);
    s[8] = last;
    s[10] = mc;
    if (last) begin
      rn = (L < RUNT);
      s[1] = crc; s[11] = rn; s[15] = crc | rn;
    end
    return s;
  endfunction

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic send_frame(input int L, input int seed, input bit mc, input bit crc);
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fbyte(seed, i, mc);
      rx_sof = (i == 0); rx_eof = (i == L - 1); rx_crc_err = crc && (i == L - 1);
      while (!rx_ready) begin @(posedge clk); @(negedge clk); end
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_err = 1'b0;
  endtask

  task automatic fill_bufs();
    for (int a = 'h100; a < 'h180; a++) mem[a] = 8'hEE;
  endtask

  task automatic rearm(input int B);
    for (int k = 0; k < 4; k++)
      set_desc(16 * perm[k], 32'h8000_0000, 32'(B) | 32'h0100_0000,
               32'h100 + 32 * perm[k], 32'(16 * perm[(k + 1) % 4]));
  endtask

  task automatic check_data(input string req, input int bp, input int L, input int B,
                            input int j, input int seed, input bit mc);
    int cnt;
    bit ok;
    logic [7:0] av, ev;
    cnt = (L - j * B < B) ? L - j * B : B;
    ok = 1; av = 0; ev = 0;
    for (int m = 0; m < cnt; m++)
      if (ok && mem[bp + m] !== fbyte(seed, j * B + m, mc)) begin
        ok = 0; av = mem[bp + m]; ev = fbyte(seed, j * B + m, mc);
      end
    chk(req, {24'b0, av}, {24'b0, ev});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    int pos, n, slot, seed;
    bit mc, crc;
    for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 / R11: reset state
    #1;
    chk("R11 reset rx_ready", {31'b0, rx_ready}, 32'd1);
    chk("R10 reset no mem_req", {31'b0, mem_req}, 32'd0);
    cfg_read(2'd2, rv); chk("R8 reset missed count", rv, 32'd0);
    cfg_read(2'd0, rv); chk("R10 reset run", rv, 32'd0);

    // Sweep of buffer sizes and frame lengths over a chained, permuted ring
    seed = 1;
    for (int B = 3; B <= 5; B++) begin
      cfg_write(2'd0, 32'd0);
      repeat (20) @(posedge clk);
      rearm(B); fill_bufs();
      cfg_write(2'd1, 32'(16 * perm[0]));
      cfg_write(2'd0, 32'd2);
      if (B == 3) begin
        @(negedge clk);
        chk("R11 rx_ready low during fetch", {31'b0, rx_ready}, 32'd0);
        chk("R1 first read at ring base", mem_addr, 32'(16 * perm[0]));
      end
      pos = 0;
      repeat (20) @(posedge clk);
      for (int L = 1; L <= 12; L++) begin
        mc = L[0]; crc = (L % 3 == 0);
        @(negedge clk); rearm(B); fill_bufs();
        repeat (20) @(posedge clk);
        send_frame(L, seed, mc, crc);
        repeat (40) @(posedge clk);
        n = (L + B - 1) / B;
        for (int j = 0; j < n; j++) begin
          slot = perm[(pos + j) % 4];
          chk("R1 R2 R4 R5 R6 R7 status", rd32(16 * slot), exp_st(L, B, j, mc, crc));
          check_data("R3 buffer bytes", 'h100 + 32 * slot, L, B, j, seed, mc);
          if (j == n - 1)
            chk("R3 byte past end untouched", {24'b0, mem['h100 + 32 * slot + (L - j * B)]},
                32'h0000_00EE);
        end
        pos = (pos + n) % 4;
        seed++;
      end
    end
    cfg_read(2'd2, rv); chk("R8 no misses during sweep", rv, 32'd0);

    // R1: unchained descriptor steps by 16 and ignores its link word
    cfg_write(2'd0, 32'd0);
    repeat (20) @(posedge clk);
    fill_bufs();
    set_desc('h80, 32'h8000_0000, 32'd4, 32'h100, 32'h0);
    set_desc('h90, 32'h8000_0000, 32'h0100_0004, 32'h120, 32'h80);
    cfg_write(2'd1, 32'h80);
    cfg_write(2'd0, 32'd2);
    repeat (20) @(posedge clk);
    send_frame(6, 40, 1'b0, 1'b0);
    repeat (40) @(posedge clk);
    chk("R1 unchained first desc", rd32('h80), exp_st(6, 4, 0, 1'b0, 1'b0));
    chk("R1 unchained next at +16", rd32('h90), exp_st(6, 4, 1, 1'b0, 1'b0));

    // R8: frame arriving at a software-owned descriptor is dropped and counted
    cfg_write(2'd0, 32'd0);
    repeat (20) @(posedge clk);
    fill_bufs();
    set_desc('hC0, 32'h0, 32'h0100_0008, 32'h140, 32'hC0);
    cfg_write(2'd1, 32'hC0);
    cfg_write(2'd0, 32'd2);
    repeat (20) @(posedge clk);
    send_frame(5, 41, 1'b0, 1'b0);
    repeat (40) @(posedge clk);
    cfg_read(2'd2, rv); chk("R8 missed count after drop", rv, 32'd1);
    chk("R8 descriptor untouched", rd32('hC0), 32'h0);
    chk("R8 buffer untouched", {24'b0, mem['h140]}, 32'h0000_00EE);
    @(negedge clk); wr32('hC0, 32'h8000_0000);
    repeat (30) @(posedge clk);
    send_frame(5, 42, 1'b1, 1'b1);
    repeat (40) @(posedge clk);
    chk("R8 repolled descriptor used", rd32('hC0), exp_st(5, 8, 0, 1'b1, 1'b1));
    check_data("R8 repolled buffer bytes", 'h140, 5, 8, 0, 42, 1'b1);
    cfg_read(2'd2, rv); chk("R8 count unchanged on success", rv, 32'd1);

    // R9: spanning frame meets a software-owned next descriptor
    cfg_write(2'd0, 32'd0);
    repeat (20) @(posedge clk);
    fill_bufs();
    set_desc('hC0, 32'h8000_0000, 32'h0100_0004, 32'h140, 32'hD0);
    set_desc('hD0, 32'h0, 32'h0100_0004, 32'h160, 32'hC0);
    cfg_write(2'd1, 32'hC0);
    cfg_write(2'd0, 32'd2);
    repeat (20) @(posedge clk);
    send_frame(10, 43, 1'b1, 1'b0);
    repeat (40) @(posedge clk);
    chk("R9 first part written without last", rd32('hC0), 32'h0004_0600);
    cfg_read(2'd2, rv); chk("R9 missed count after truncation", rv, 32'd2);
    chk("R9 second buffer untouched", {24'b0, mem['h160]}, 32'h0000_00EE);

    // R10: with run clear, frames are discarded and memory is left alone
    cfg_write(2'd0, 32'd0);
    repeat (20) @(posedge clk);
    @(negedge clk); wr32('hD0, 32'h8000_0000);
    send_frame(4, 44, 1'b0, 1'b0);
    repeat (40) @(posedge clk);
    chk("R10 stopped descriptor untouched", rd32('hD0), 32'h8000_0000);
    chk("R10 stopped buffer untouched", {24'b0, mem['h160]}, 32'h0000_00EE);
    cfg_read(2'd2, rv); chk("R10 stopped no miss count", rv, 32'd2);
    cfg_read(2'd0, rv); chk("R10 run readback", rv, 32'd0);
    cfg_read(2'd1, rv); chk("R10 base readback", rv, 32'hC0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule